// File: doc/BRIEF.md
# Fractional Frequency Trim Generator

This block fine-tunes the rate of a time-of-day counter. Software programs an interval: the amount of elapsed time that should pass between two one-nanosecond corrections. On every clock the block adds the time that one clock period represents to an accumulator. Each time the accumulator reaches the interval, the block emits a single correction pulse and keeps the remainder. Because the remainder is kept, the long-run correction rate is exact even when the interval is not a multiple of the clock period.

The interval is a 30-bit value. A unit bit selects whether it counts picoseconds, for fine trims, or nanoseconds, for very small trims whose interval would not fit in 30 bits of picoseconds. A direction bit sends the pulses either to an "add one nanosecond" output, which speeds the counter up, or to a "drop one nanosecond" output, which slows it down. Writing all zeros to the config word turns trimming off, and the counter then runs at its nominal rate. Any register write restarts the accumulator from zero, so a new setting starts with a clean phase.

Top module: `freq_trim`

## Requirements
- R1: After reset both correction outputs stay low, and they stay low until a config write with the enable bit set.
- R2: While the enable bit (config bit 0) is 0, neither trimAdd nor trimDrop is ever asserted.
- R3: With the unit bit (interval word bit 30) at 0, each enabled clock adds STEP_PS picoseconds. Exactly floor(N*STEP_PS/ivl) pulses appear in the N clocks that follow the last register write.
- R4: With the unit bit at 1, each enabled clock adds STEP_NS nanoseconds. Exactly floor(N*STEP_NS/ivl) pulses appear in the N clocks that follow the last register write.
- R5: With the direction bit (config bit 1) at 0, the pulses appear on trimAdd. With it at 1 they appear on trimDrop. The two outputs are never high together.
- R6: An interval smaller than one clock's step, zero included, gives one pulse on every enabled clock and never more than one.
- R7: A write to either register clears the accumulator and suppresses the pulse in the next cycle. After the write, the first pulse comes ceil(ivl/step) clocks later.
- R8: Writing zero to the config word stops the pulses from the next clock onward.
- R9: Interval word bit 31 and config bits 31:2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period equals STEP_PS picoseconds of time |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the interval word, 1 selects the config word |
| wrData | input | 32 | Write data: interval in bits 29:0 and unit in bit 30; enable in bit 0 and direction in bit 1 |
| trimAdd | output | 1 | One-cycle pulse: add one nanosecond |
| trimDrop | output | 1 | One-cycle pulse: remove one nanosecond |

## Verification
The assertions check on every cycle that the two outputs are mutually exclusive and that each pulse matches the direction in force at the time. They also check that nothing fires while disabled, right after a write, or right after reset. The exact pulse count per interval, the kept remainder, the picosecond and nanosecond unit scaling, the phase restart and the ignored bits are properties of sequences of cycles. Only the bench's scenarios show these, by comparison against its reference model and by counting pulses over windows.

// File: rtl/freq_trim_pkg.sv
package freq_trim_pkg;
  // Strobes from the register control to the accumulator datapath
  typedef struct packed {
    logic clrAcc;  // a register write happens this cycle
    logic run;     // trimming enabled
    logic dirNeg;  // 1: slow the counter down
    logic unitNs;  // 1: interval counted in nanoseconds
  } trimStrobes_t;
endpackage

// File: rtl/freq_trim_ctrl.sv
module freq_trim_ctrl
  import freq_trim_pkg::*;
#(
  parameter int IVL_W  = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output trimStrobes_t      strb,
  output logic [IVL_W-1:0]  ivl
);
  localparam int UNIT_POS = IVL_W;
  localparam int EN_POS   = 0;
  localparam int DIR_POS  = 1;

  logic unitReg, enReg, dirReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivl     <= '0;
      unitReg <= 1'b0;
      enReg   <= 1'b0;
      dirReg  <= 1'b0;
    end else if (wrEn) begin
      if (!wrSel) begin
        ivl     <= wrData[IVL_W-1:0];
        unitReg <= wrData[UNIT_POS];
      end else begin
        enReg  <= wrData[EN_POS];
        dirReg <= wrData[DIR_POS];
      end
    end
  end

  always_comb begin
    strb.clrAcc = wrEn;
    strb.run    = enReg;
    strb.dirNeg = dirReg;
    strb.unitNs = unitReg;
  end
endmodule

// File: rtl/freq_trim_dp.sv
module freq_trim_dp
  import freq_trim_pkg::*;
#(
  parameter int IVL_W   = 30,
  parameter int STEP_NS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  trimStrobes_t     strb,
  input  logic [IVL_W-1:0] ivl,
  output logic             trimAdd,
  output logic             trimDrop
);
  localparam int ACC_W   = IVL_W + 1;
  localparam int STEP_PS = STEP_NS * 1000;

  logic [ACC_W-1:0] acc, step, ivlExt, ivlEff, sum;
  logic hit;

  always_comb begin
    step   = strb.unitNs ? ACC_W'(STEP_NS) : ACC_W'(STEP_PS);
    ivlExt = {1'b0, ivl};
    ivlEff = (ivlExt < step) ? step : ivlExt;
    sum    = acc + step;
    hit    = (sum >= ivlEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      trimAdd  <= 1'b0;
      trimDrop <= 1'b0;
    end else if (strb.clrAcc || !strb.run) begin
      acc      <= '0;
      trimAdd  <= 1'b0;
      trimDrop <= 1'b0;
    end else begin
      acc      <= hit ? (sum - ivlEff) : sum;
      trimAdd  <= hit & ~strb.dirNeg;
      trimDrop <= hit & strb.dirNeg;
    end
  end
endmodule

// File: rtl/freq_trim.sv
module freq_trim
  import freq_trim_pkg::*;
#(
  parameter int IVL_W   = 30,
  parameter int DATA_W  = 32,
  parameter int STEP_NS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              trimAdd,
  output logic              trimDrop
);
  trimStrobes_t     strb;
  logic [IVL_W-1:0] ivl;

  freq_trim_ctrl #(.IVL_W(IVL_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strb(strb), .ivl(ivl)
  );

  freq_trim_dp #(.IVL_W(IVL_W), .STEP_NS(STEP_NS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ivl(ivl),
    .trimAdd(trimAdd), .trimDrop(trimDrop)
  );
endmodule

// File: rtl/freq_trim_chk.sv
module freq_trim_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic run,
  input logic dirNeg,
  input logic trimAdd,
  input logic trimDrop
);
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    !(trimAdd && trimDrop)); // R5
  AST_ADD_MATCHES_DIR: assert property (@(posedge clk) disable iff (!rstN)
    trimAdd |-> !$past(dirNeg)); // R5
  AST_DROP_MATCHES_DIR: assert property (@(posedge clk) disable iff (!rstN)
    trimDrop |-> $past(dirNeg)); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (!trimAdd && !trimDrop)); // R2
  AST_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (!trimAdd && !trimDrop)); // R7
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!trimAdd && !trimDrop)); // R1
endmodule

bind freq_trim freq_trim_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .run(strb.run), .dirNeg(strb.dirNeg),
  .trimAdd(trimAdd), .trimDrop(trimDrop)
);

// File: tb/freq_trim_test.sv
`timescale 1ns/1ps
module freq_trim_test;
  localparam int STEP_NS = 4;
  localparam int STEP_PS = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic trimAdd, trimDrop;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  longint mIvl = 0;
  bit mUnitNs = 0, mEn = 0, mDir = 0;
  longint mAcc = 0;
  bit expAdd = 0, expDrop = 0;

  always #2 clk = ~clk;

  freq_trim #(.STEP_NS(STEP_NS)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .trimAdd(trimAdd), .trimDrop(trimDrop)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference: elapsed time against the programmed interval
  always @(posedge clk) begin
    if (!rstN) begin
      mIvl = 0; mUnitNs = 0; mEn = 0; mDir = 0; mAcc = 0;
      expAdd = 0; expDrop = 0;
    end else if (wrEn) begin
      if (!wrSel) begin
        mIvl = longint'(wrData & 32'h3FFF_FFFF);
        mUnitNs = wrData[30];
      end else begin
        mEn = wrData[0];
        mDir = wrData[1];
      end
      mAcc = 0; expAdd = 0; expDrop = 0;
    end else if (!mEn) begin
      mAcc = 0; expAdd = 0; expDrop = 0;
    end else begin
      longint st, iv;
      st = mUnitNs ? STEP_NS : STEP_PS;
      iv = (mIvl < st) ? st : mIvl;
      mAcc = mAcc + st;
      if (mAcc >= iv) begin
        mAcc = mAcc - iv;
        expAdd = !mDir; expDrop = mDir;
      end else begin
        expAdd = 0; expDrop = 0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(trimAdd === expAdd, "R3 model trimAdd", longint'(trimAdd), longint'(expAdd));
      check(trimDrop === expDrop, "R5 model trimDrop", longint'(trimDrop), longint'(expDrop));
    end
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      finishRun();
    end
  end

  task automatic writeReg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic runCount(input int n, output int nAdd, output int nDrop);
    nAdd = 0; nDrop = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nAdd += int'(trimAdd);
      nDrop += int'(trimDrop);
    end
  endtask

  initial begin
    int a, d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet after reset, even with an interval programmed
    runCount(20, a, d);
    check(a == 0 && d == 0, "R1 reset quiet", a + d, 0);
    writeReg(0, 32'd10000);
    runCount(30, a, d);
    check(a == 0 && d == 0, "R1 no enable yet", a + d, 0);

    // R3: picoseconds, 10000 ps interval, 4000 ps per clock
    writeReg(1, 32'h1);
    runCount(1000, a, d);
    check(a == 400, "R3 ps count", a, 400);
    check(d == 0, "R5 no drop when dir=0", d, 0);

    // R4: nanoseconds, 7 ns interval
    writeReg(0, 32'h4000_0007);
    runCount(700, a, d);
    check(a == 400, "R4 ns count", a, 400);

    // R5: slow-down direction
    writeReg(1, 32'h3);
    runCount(350, a, d);
    check(d == 200, "R5 drop count", d, 200);
    check(a == 0, "R5 no add when dir=1", a, 0);

    // R7: phase restart, 9000 ps needs 3 clocks
    writeReg(1, 32'h1);
    writeReg(0, 32'd9000);
    runCount(2, a, d);
    check(a == 0, "R7 no early pulse", a, 0);
    runCount(1, a, d);
    check(a == 1, "R7 first pulse at ceil", a, 1);
    runCount(2, a, d);
    writeReg(0, 32'd9000);
    runCount(2, a, d);
    check(a == 0, "R7 restart clears phase", a, 0);
    runCount(1, a, d);
    check(a == 1, "R7 restart first pulse", a, 1);

    // R6: intervals below one step, including zero
    writeReg(0, 32'd1000);
    runCount(50, a, d);
    check(a == 50, "R6 small interval", a, 50);
    writeReg(0, 32'd0);
    runCount(50, a, d);
    check(a == 50, "R6 zero interval", a, 50);
    writeReg(0, 32'h4000_0002);
    runCount(40, a, d);
    check(a == 40, "R6 ns small interval", a, 40);

    // R8 and R2: disable
    writeReg(1, 32'h0);
    runCount(100, a, d);
    check(a == 0 && d == 0, "R8 config zero stops", a + d, 0);
    writeReg(0, 32'd10000);
    runCount(100, a, d);
    check(a == 0 && d == 0, "R2 stays off", a + d, 0);

    // R9: ignored bits
    writeReg(1, 32'hFFFF_FFFC);
    runCount(100, a, d);
    check(a == 0 && d == 0, "R9 upper config bits ignored", a + d, 0);
    writeReg(1, 32'hFFFF_FFF1);
    writeReg(0, 32'h8000_2710);
    runCount(1000, a, d);
    check(a == 400, "R9 bit31 ignored ps unit kept", a, 400);
    check(d == 0, "R9 direction from bit1 only", d, 0);

    finishRun();
  end
endmodule